// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block runs one multi-register load or store. It accepts a command that holds a register-select mask, a base address and five control bits. From these it produces a stream of single-word memory requests, one for each selected register, always from the lowest selected index to the highest. Each request carries the word address, the register index and a tag that says whether the access follows on from the previous one. The block also tells the register file when and with what value to update the base register. It flags when the user register bank must stand in for the current one, when the saved status word must be copied back, and when the next instruction fetch must start a fresh burst.

The command side is a valid/ready port. `cmd_ready` is high only while the block is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The request side is also valid/ready. Once `req_valid` is high, the request stays high and its address, index and tag stay unchanged until the edge where `req_ready` is high. The memory may hold `req_ready` low for any number of cycles. The base-update, bank, restore and fetch pins are single-cycle or level controls with no handshake. The block's work finishes with a one-cycle `done` pulse.

Top module: `blk_xfer_seq`

## Requirements
- R1: `cmd_ready` is high in idle and after reset. It is low from the edge that accepts a command up to and including the `done` cycle.
- R2: There is exactly one request for each set bit of `cmd_list`. The requests come in ascending index order, and `req_reg` gives that index.
- R3: The mode is encoded as {pre, up}. With n set bits, the first address is `base` for 01, `base+4` for 11, `base-4n` for 10 and `base-4n+4` for 00. Each later request is 4 above the one before, and all arithmetic wraps modulo 2^AW.
- R4: `req_seq` is 0 on the first request of a command and 1 on every later request.
- R5: While `req_valid` is high and `req_ready` is low, the request and all of its fields stay unchanged.
- R6: For a load with writeback, `base_we` pulses once, one cycle after acceptance, and the first request follows in the next cycle. `base_val` is `base+4n` when up=1 and `base-4n` when up=0.
- R7: For a store with writeback, `base_we` pulses once, in the `done` cycle, with the same value as in R6.
- R8: When writeback is 0 or the list is empty, `base_we` never pulses.
- R9: When `cmd_user` is set, `user_bank` is high on every request of a store, or of a load whose list leaves out index NREG-1. It is low at all other times.
- R10: `psr_restore` pulses in the `done` cycle only for a load with `cmd_user` set and bit NREG-1 in the list, while `cmd_nosaved` (current mode has no saved status word) is low.
- R11: For a load, `done` comes two cycles after the edge that accepts the last request, leaving one idle cycle. For a store, `done` comes one cycle after that edge, and `fetch_nonseq` is high with it.
- R12: An empty list makes no request, and `done` follows in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_list | input | NREG | Register-select mask |
| cmd_base | input | AW | Base address |
| cmd_pre | input | 1 | Step before access |
| cmd_up | input | 1 | Ascending block |
| cmd_user | input | 1 | User-bank / status-restore request |
| cmd_wb | input | 1 | Update base register |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_nosaved | input | 1 | Current mode has no saved status word |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | AW | Word address |
| req_reg | output | IW | Register index |
| req_seq | output | 1 | Sequential access tag |
| req_load | output | 1 | Request direction |
| user_bank | output | 1 | Use user register bank |
| base_we | output | 1 | Base register write strobe |
| base_val | output | AW | New base value |
| psr_restore | output | 1 | Copy saved status to current |
| fetch_nonseq | output | 1 | Next fetch non-sequential |
| done | output | 1 | Command finished |

## Verification
The bench uses the default parameters: a 16-entry list, 32-bit addresses and 4-byte words. With these it can reach the top register index, which drives the status-restore and bank-selection rules. It can also reach a full list, whose descending start address wraps below zero. The memory side is run both always ready and ready on alternate cycles, so the request-hold rule and the timing of writeback and `done` are checked under stalls.

// File: rtl/blk_xfer_seq_pkg.sv
package blk_xfer_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_XFER,
    ST_GAP,
    ST_FIN
  } xfer_state_e;
endpackage

// File: rtl/blk_xfer_popcount.sv
module blk_xfer_popcount #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/blk_xfer_lowest.sv
module blk_xfer_lowest #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          only_one
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
  assign only_one = ((bits & (bits - W'(1))) == '0);
endmodule

// File: rtl/blk_xfer_addr_gen.sv
module blk_xfer_addr_gen #(
  parameter int AW    = 32,
  parameter int CW    = 5,
  parameter int BYTES = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          pre,
  input  logic          up,
  output logic [AW-1:0] start,
  output logic [AW-1:0] new_base
);
  logic [AW-1:0] span;
  assign span = AW'(count) * AW'(BYTES);

  always_comb begin
    unique case ({pre, up})
      2'b01:   start = base;
      2'b11:   start = base + AW'(BYTES);
      2'b10:   start = base - span;
      default: start = base - span + AW'(BYTES);
    endcase
    new_base = up ? base + span : base - span;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int NREG  = 16,
  parameter int AW    = 32,
  parameter int BYTES = 4,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_list,
  input  logic [AW-1:0]   cmd_base,
  input  logic            cmd_pre,
  input  logic            cmd_up,
  input  logic            cmd_user,
  input  logic            cmd_wb,
  input  logic            cmd_load,
  input  logic            cmd_nosaved,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [IW-1:0]   req_reg,
  output logic            req_seq,
  output logic            req_load,
  output logic            user_bank,
  output logic            base_we,
  output logic [AW-1:0]   base_val,
  output logic            psr_restore,
  output logic            fetch_nonseq,
  output logic            done
);
  import blk_xfer_seq_pkg::*;

  localparam int TOP = NREG - 1;

  xfer_state_e     state;
  logic [NREG-1:0] rem;
  logic [AW-1:0]   addr;
  logic            first, load_r, wb_r, ub_r, restore_r;
  logic [AW-1:0]   wbval_r;

  logic [CW-1:0]   n_sel;
  logic [AW-1:0]   start_addr, next_base;
  logic [IW-1:0]   cur_idx;
  logic            last_one;
  logic            list_empty;

  blk_xfer_popcount #(.W(NREG), .CW(CW)) u_count (
    .bits(cmd_list), .count(n_sel)
  );

  blk_xfer_addr_gen #(.AW(AW), .CW(CW), .BYTES(BYTES)) u_addr (
    .base(cmd_base), .count(n_sel), .pre(cmd_pre), .up(cmd_up),
    .start(start_addr), .new_base(next_base)
  );

  blk_xfer_lowest #(.W(NREG), .IW(IW)) u_low (
    .bits(rem), .idx(cur_idx), .only_one(last_one)
  );

  assign list_empty = (cmd_list == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rem       <= '0;
      addr      <= '0;
      first     <= 1'b0;
      load_r    <= 1'b0;
      wb_r      <= 1'b0;
      ub_r      <= 1'b0;
      restore_r <= 1'b0;
      wbval_r   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          rem       <= cmd_list;
          addr      <= start_addr;
          first     <= 1'b1;
          load_r    <= cmd_load;
          wb_r      <= cmd_wb && !list_empty;
          ub_r      <= cmd_user && (!cmd_load || !cmd_list[TOP]);
          restore_r <= cmd_load && cmd_user && cmd_list[TOP] && !cmd_nosaved;
          wbval_r   <= next_base;
          if (list_empty)           state <= ST_FIN;
          else if (cmd_load && cmd_wb) state <= ST_PRE;
          else                      state <= ST_XFER;
        end
        ST_PRE: state <= ST_XFER;
        ST_XFER: if (req_ready) begin
          rem   <= rem & (rem - NREG'(1));
          addr  <= addr + AW'(BYTES);
          first <= 1'b0;
          if (last_one) state <= load_r ? ST_GAP : ST_FIN;
        end
        ST_GAP: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign req_valid    = (state == ST_XFER);
  assign req_addr     = addr;
  assign req_reg      = cur_idx;
  assign req_seq      = !first;
  assign req_load     = load_r;
  assign user_bank    = (state == ST_XFER) && ub_r;
  assign base_we      = wb_r && ((state == ST_PRE) || ((state == ST_FIN) && !load_r));
  assign base_val     = wbval_r;
  assign done         = (state == ST_FIN);
  assign psr_restore  = (state == ST_FIN) && restore_r;
  assign fetch_nonseq = (state == ST_FIN) && !load_r;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int AW    = 32,
  parameter int IW    = 4,
  parameter int BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [IW-1:0] req_reg,
  input logic          req_seq,
  input logic          user_bank,
  input logic          base_we,
  input logic          psr_restore,
  input logic          fetch_nonseq,
  input logic          done
);
  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || (req_addr == $past(req_addr) + AW'(BYTES)));

  assert_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !req_seq);

  assert_later_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid || req_seq);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_seq));

  assert_wb_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_we && req_valid));

  assert_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    user_bank |-> req_valid);

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> done);

  assert_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_nonseq |-> done);

  assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW), .IW(IW), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_reg(req_reg), .req_seq(req_seq), .user_bank(user_bank),
  .base_we(base_we), .psr_restore(psr_restore), .fetch_nonseq(fetch_nonseq),
  .done(done)
);

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_list = '0;
  logic [31:0] cmd_base = '0;
  logic        cmd_pre = 1'b0, cmd_up = 1'b0, cmd_user = 1'b0, cmd_wb = 1'b0;
  logic        cmd_load = 1'b0, cmd_nosaved = 1'b0;
  logic        req_valid, req_ready, req_seq, req_load;
  logic [31:0] req_addr;
  logic [3:0]  req_reg;
  logic        user_bank, base_we, psr_restore, fetch_nonseq, done;
  logic [31:0] base_val;

  int  cyc = 0;
  bit  stall_en = 1'b0;
  int  n_checks = 0, n_fail = 0;
  bit  summary_done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign req_ready = !stall_en || cyc[0];

  blk_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_list(cmd_list), .cmd_base(cmd_base), .cmd_pre(cmd_pre), .cmd_up(cmd_up),
    .cmd_user(cmd_user), .cmd_wb(cmd_wb), .cmd_load(cmd_load),
    .cmd_nosaved(cmd_nosaved), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_reg(req_reg), .req_seq(req_seq), .req_load(req_load),
    .user_bank(user_bank), .base_we(base_we), .base_val(base_val),
    .psr_restore(psr_restore), .fetch_nonseq(fetch_nonseq), .done(done)
  );

  // monitor log
  int          n_acc, bw_cnt, done_cnt, ub_stray, stab_err, side_stray;
  int          acc_cyc [32];
  logic [31:0] acc_addr [32];
  int          acc_reg [32];
  bit          acc_seq [32], acc_ub [32], acc_ld [32];
  int          bw_cyc, done_cyc;
  logic [31:0] bw_val;
  bit          psr_at, fnz_at, hold_prev;
  logic [31:0] prev_addr;
  logic [3:0]  prev_reg;

  always @(negedge clk) if (rst_n) begin
    if (req_valid && req_ready && n_acc < 32) begin
      acc_cyc[n_acc]  = cyc;
      acc_addr[n_acc] = req_addr;
      acc_reg[n_acc]  = int'(req_reg);
      acc_seq[n_acc]  = req_seq;
      acc_ub[n_acc]   = user_bank;
      acc_ld[n_acc]   = req_load;
      n_acc++;
    end
    if (user_bank && !req_valid) ub_stray++;
    if (hold_prev && (!req_valid || req_addr != prev_addr || req_reg != prev_reg)) stab_err++;
    hold_prev = req_valid && !req_ready;
    prev_addr = req_addr;
    prev_reg  = req_reg;
    if (base_we) begin bw_cnt++; bw_cyc = cyc; bw_val = base_val; end
    if (done) begin done_cnt++; done_cyc = cyc; psr_at = psr_restore; fnz_at = fetch_nonseq; end
    if ((psr_restore || fetch_nonseq) && !done) side_stray++;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // run one command and compare all observations with values derived from the requirements
  task automatic do_op(input logic [15:0] lst, input logic [31:0] base, input bit pre,
                       input bit up, input bit s, input bit wb, input bit ld,
                       input bit ns, input bit stl, input string tag);
    int c0, n, k, waited, first_c;
    int exp_reg [16];
    logic [31:0] start, span, nb;
    bit exp_ub;
    @(negedge clk);
    n_acc = 0; bw_cnt = 0; done_cnt = 0; ub_stray = 0; stab_err = 0; side_stray = 0;
    hold_prev = 1'b0;
    stall_en = stl;
    c0 = cyc;
    chk(cmd_ready == 1'b1, {tag, " R1 idle ready"}, cmd_ready, 1);
    cmd_list = lst; cmd_base = base; cmd_pre = pre; cmd_up = up; cmd_user = s;
    cmd_wb = wb; cmd_load = ld; cmd_nosaved = ns; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b0, {tag, " R1 busy"}, cmd_ready, 0);
    waited = 0;
    while (done_cnt == 0 && waited < 500) begin @(negedge clk); waited++; end
    @(negedge clk);
    chk(done_cnt == 1, {tag, " R11 done pulse"}, done_cnt, 1);

    n = 0;
    for (int i = 0; i < 16; i++) if (lst[i]) begin exp_reg[n] = i; n++; end
    span = 32'(n) * 32'd4;
    case ({pre, up})
      2'b01:   start = base;
      2'b11:   start = base + 32'd4;
      2'b10:   start = base - span;
      default: start = base - span + 32'd4;
    endcase
    nb = up ? base + span : base - span;
    exp_ub = s && (!ld || !lst[15]);

    chk(n_acc == n, {tag, " R2 access count"}, n_acc, n);
    if (n_acc == n) begin
      for (k = 0; k < n; k++) begin
        chk(acc_reg[k] == exp_reg[k], {tag, " R2 order"}, acc_reg[k], exp_reg[k]);
        chk(acc_addr[k] == start + 32'(k) * 32'd4, {tag, " R3 address"}, acc_addr[k], start + 32'(k) * 32'd4);
        chk(acc_seq[k] == (k != 0), {tag, " R4 seq tag"}, acc_seq[k], (k != 0));
        chk(acc_ub[k] == exp_ub, {tag, " R9 user bank"}, acc_ub[k], exp_ub);
        chk(acc_ld[k] == ld, {tag, " R2 direction"}, acc_ld[k], ld);
      end
      if (n > 0) begin
        first_c = c0 + 1 + ((ld && wb) ? 1 : 0);
        chk(acc_cyc[0] >= first_c, {tag, " R6 first request cycle"}, acc_cyc[0], first_c);
        if (!stl) chk(acc_cyc[0] == first_c, {tag, " R6 first request cycle"}, acc_cyc[0], first_c);
        chk(done_cyc == acc_cyc[n-1] + (ld ? 2 : 1), {tag, " R11 done timing"}, done_cyc, acc_cyc[n-1] + (ld ? 2 : 1));
      end else begin
        chk(done_cyc == c0 + 1, {tag, " R12 empty done timing"}, done_cyc, c0 + 1);
      end
    end
    if (wb && n > 0) begin
      chk(bw_cnt == 1, {tag, " R6 R7 base write count"}, bw_cnt, 1);
      chk(bw_val == nb, {tag, " R6 R7 base value"}, bw_val, nb);
      if (ld) chk(bw_cyc == c0 + 1, {tag, " R6 load base write cycle"}, bw_cyc, c0 + 1);
      else    chk(bw_cyc == done_cyc, {tag, " R7 store base write cycle"}, bw_cyc, done_cyc);
    end else begin
      chk(bw_cnt == 0, {tag, " R8 no base write"}, bw_cnt, 0);
    end
    chk(psr_at == (ld && s && lst[15] && !ns), {tag, " R10 restore"}, psr_at, (ld && s && lst[15] && !ns));
    chk(fnz_at == !ld, {tag, " R11 fetch nonseq"}, fnz_at, !ld);
    chk(stab_err == 0, {tag, " R5 hold under stall"}, stab_err, 0);
    chk(ub_stray == 0, {tag, " R9 bank outside transfer"}, ub_stray, 0);
    chk(side_stray == 0, {tag, " R10 R11 pulse outside done"}, side_stray, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    chk(req_valid == 1'b0, "R2 reset no request", req_valid, 0);
    chk(done == 1'b0 && base_we == 1'b0, "R8 reset quiet", {done, base_we}, 0);
  endtask

  task automatic t_ia_load_wb();   do_op(16'h00F1, 32'h0000_1000, 0, 1, 0, 1, 1, 0, 0, "IA load wb"); endtask
  task automatic t_ib_store_wb();  do_op(16'h0A06, 32'h0000_2000, 1, 1, 0, 1, 0, 0, 1, "IB store wb stall"); endtask
  task automatic t_db_load_user(); do_op(16'h1230, 32'h0000_3000, 1, 0, 1, 0, 1, 0, 0, "DB load user"); endtask
  task automatic t_da_store_user();do_op(16'h8081, 32'h0000_4000, 0, 0, 1, 1, 0, 0, 1, "DA store user wb"); endtask
  task automatic t_restore();      do_op(16'h8003, 32'h0000_5000, 0, 1, 1, 1, 1, 0, 0, "load r15 restore"); endtask
  task automatic t_no_restore();   do_op(16'h8003, 32'h0000_5000, 0, 1, 1, 0, 1, 1, 1, "load r15 nosaved"); endtask
  task automatic t_empty();        do_op(16'h0000, 32'h0000_6000, 0, 1, 0, 1, 1, 0, 0, "R12 empty list"); endtask
  task automatic t_full_wrap();    do_op(16'hFFFF, 32'h0000_0020, 1, 0, 0, 1, 0, 0, 1, "full DB wrap"); endtask
  task automatic t_single_top();   do_op(16'h8000, 32'hFFFF_FFFC, 0, 1, 0, 1, 0, 0, 0, "single top store"); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ia_load_wb();
    t_ib_store_wb();
    t_db_load_user();
    t_da_store_user();
    t_restore();
    t_no_restore();
    t_empty();
    t_full_wrap();
    t_single_top();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end
endmodule